// File: doc/BRIEF.md
# LED Driver Register Target on a Two-Wire Bus

This block is the register front end of a multi-channel LED driver. It acts as a target on an I2C bus and lets a host reach a 114-byte register space: one control byte, a 10-bit fine duty and an 8-bit coarse duty for each of 36 channels, three group current bytes (for the G, R and B channel groups) and one phase control byte. Writes may carry one byte or many; reads use a pointer write, a repeated start and then a read address.

Duty values are double buffered. A host write lands in a staged copy, and the PWM logic sees it only after the update location is written, so that a whole frame of new values changes at once. Control, group current and phase bytes act as soon as they are written. A clear location returns the whole space to zero. A rising edge on the shutdown pin aborts any transfer in progress.

SCL and SDA arrive already synchronised to `clk`. The block pulls SDA low through `sda_oe_o`, and the pad forms the wired-AND.

Top module: `ledreg_i2c_target`

## Requirements
- R1: The target answers only to the 7-bit address {01100, strap_i[1:0]}, followed by the R/W bit (0 = write, 1 = read). The strap values are 00 for a pin tied to ground, 11 for supply, 01 for SCL and 10 for SDA. For any other address the target does not acknowledge that byte or any later byte before the next START.
- R2: In a write, the first byte after the address loads the register pointer. Each later byte is stored at the pointer and acknowledged, and the pointer then advances by one.
- R3: A read returns the byte at the pointer, MSB first. Each host ACK advances the pointer and sends the next byte. A host NACK ends the read and leaves SDA released.
- R4: The register map is as follows. 00h is control: bit 6 selects RGB grouping, bits 5:4 select frequency, bit 1 selects resolution and bit 0 is the shutdown bit (0 = shut down). The other control bits read 0. In 01h–48h, odd addresses hold a channel's low 8 duty bits and the next even address holds its top 2 bits, in bits 1:0, with bits 7:2 reading 0. 49h–6Ch hold the coarse duty for channels 1–36. 6Eh, 6Fh and 70h hold the G, R and B group currents. 71h is phase control. 6Dh, 7Fh, 72h–7Eh and 80h–FFh read 00h.
- R5: Duty writes (01h–6Ch) are staged. fine_o and coarse_o change only when 00h is written to 6Dh while pin_i is high and control bit 0 is 1. Any other write to 6Dh, or a write of 00h to 6Dh under any other condition, changes nothing.
- R6: Writing 00h to 7Fh sets every register and every active duty value to 0. A nonzero write to 7Fh has no effect.
- R7: ctrl_o, cur_g_o, cur_r_o, cur_b_o and phase_o follow their registers as soon as the write is acknowledged, with no update step.
- R8: A STOP at any point returns the bus logic to idle with SDA released. A following transfer works normally.
- R9: A rising edge on pin_i aborts the transfer in progress and releases SDA. Bytes sent after it are not acknowledged and not stored until the next START.
- R10: After rst_n, all outputs are 0 and SDA is released.
- R11: Channel k (0-based) takes fine_o[10k+9:10k] = {reg[2k+2][1:0], reg[2k+1]} and coarse_o[8k+7:8k] = reg[49h+k], both from the active copy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | Synchronised bus clock |
| sda_i | input | 1 | Synchronised bus data line |
| sda_oe_o | output | 1 | Pull SDA low when 1 |
| strap_i | input | 2 | Address strap, sets address bits 2:1 |
| pin_i | input | 1 | Shutdown pin, low = shut down |
| ctrl_o | output | 8 | Control register |
| fine_o | output | 360 | Active fine duty, 10 bits per channel |
| coarse_o | output | 288 | Active coarse duty, 8 bits per channel |
| cur_g_o | output | 8 | G group current |
| cur_r_o | output | 8 | R group current |
| cur_b_o | output | 8 | B group current |
| phase_o | output | 8 | Phase control register |

## Verification
The assertions assume that SCL and SDA are already synchronised and glitch free. They also assume that SDA changes only while SCL is low, except for START and STOP, so every edge the block sees is a real bus event. The bench host moves each line at a falling edge of `clk`, holds every line for several clock cycles and never changes SDA while SCL is high except to form START or STOP. The shutdown pin is toggled only while SCL is low.

// File: rtl/ledreg_pkg.sv
`timescale 1ns/1ps
package ledreg_pkg;
  parameter int unsigned CH_N    = 36;
  parameter int unsigned FINE_W  = 10;
  parameter int unsigned BYTE_W  = 8;
  parameter int unsigned REG_N   = 114;
  parameter logic [4:0]  DEV_HI  = 5'b01100;
  parameter logic [7:0]  CTRL_A  = 8'h00;
  parameter logic [7:0]  UPD_A   = 8'h6D;
  parameter logic [7:0]  GCC_A   = 8'h6E;
  parameter logic [7:0]  PHS_A   = 8'h71;
  parameter logic [7:0]  CLR_A   = 8'h7F;
  parameter logic [7:0]  CTRL_M  = 8'h73;

  typedef enum logic [2:0] {BUS_IDLE, BUS_RX, BUS_ACK, BUS_TX, BUS_HACK} bus_st_t;

  function automatic logic addr_match(input logic [6:0] dev, input logic [1:0] strap);
    return dev == {DEV_HI, strap};
  endfunction

  function automatic logic [7:0] reg_mask(input logic [7:0] a);
    if (a == CTRL_A) return CTRL_M;
    if (a == UPD_A) return 8'h00;
    if (a <= 8'(2 * CH_N)) return a[0] ? 8'hFF : 8'(2 ** (FINE_W - BYTE_W) - 1);
    return 8'hFF;
  endfunction
endpackage

// File: rtl/ledreg_bus.sv
`timescale 1ns/1ps
module ledreg_bus
  import ledreg_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  input  logic [1:0] strap_i,
  input  logic       pin_i,
  input  logic [7:0] rd_data_i,
  output logic       sda_oe_o,
  output logic       wr_o,
  output logic [7:0] wr_addr_o,
  output logic [7:0] wr_data_o,
  output logic [7:0] ptr_o
);
  bus_st_t    st;
  logic       scl_q, sda_q, pin_q;
  logic       is_addr, rd_mode, first, got8;
  logic [2:0] cnt;
  logic [7:0] sh, txb;

  wire start_w    = scl_q & scl_i & sda_q & ~sda_i;
  wire stop_w     = scl_q & scl_i & ~sda_q & sda_i;
  wire rise_w     = ~scl_q & scl_i;
  wire fall_w     = scl_q & ~scl_i;
  wire pin_rise_w = ~pin_q & pin_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1; sda_q <= 1'b1; pin_q <= 1'b1;
      st <= BUS_IDLE; sda_oe_o <= 1'b0; wr_o <= 1'b0;
      wr_addr_o <= '0; wr_data_o <= '0; ptr_o <= '0;
      is_addr <= 1'b0; rd_mode <= 1'b0; first <= 1'b0; got8 <= 1'b0;
      cnt <= '0; sh <= '0; txb <= '0;
    end else begin
      scl_q <= scl_i; sda_q <= sda_i; pin_q <= pin_i;
      wr_o <= 1'b0;
      if (pin_rise_w) begin
        st <= BUS_IDLE; sda_oe_o <= 1'b0; got8 <= 1'b0;
      end else if (start_w) begin
        st <= BUS_RX; is_addr <= 1'b1; cnt <= '0; got8 <= 1'b0; sda_oe_o <= 1'b0;
      end else if (stop_w) begin
        st <= BUS_IDLE; sda_oe_o <= 1'b0; got8 <= 1'b0;
      end else begin
        unique case (st)
          BUS_RX: begin
            if (rise_w) begin
              sh   <= {sh[6:0], sda_i};
              cnt  <= cnt + 3'd1;
              got8 <= (cnt == 3'd7);
            end else if (fall_w && got8) begin
              got8 <= 1'b0;
              cnt  <= '0;
              if (is_addr) begin
                is_addr <= 1'b0;
                if (addr_match(sh[7:1], strap_i)) begin
                  sda_oe_o <= 1'b1; st <= BUS_ACK;
                  rd_mode <= sh[0]; first <= ~sh[0];
                end else begin
                  st <= BUS_IDLE;
                end
              end else begin
                sda_oe_o <= 1'b1; st <= BUS_ACK;
                if (first) begin
                  ptr_o <= sh; first <= 1'b0;
                end else begin
                  wr_o <= 1'b1; wr_addr_o <= ptr_o; wr_data_o <= sh;
                  ptr_o <= ptr_o + 8'd1;
                end
              end
            end
          end
          BUS_ACK: if (fall_w) begin
            cnt <= '0;
            if (rd_mode) begin
              st <= BUS_TX; txb <= rd_data_i; sda_oe_o <= ~rd_data_i[7];
            end else begin
              st <= BUS_RX; sda_oe_o <= 1'b0;
            end
          end
          BUS_TX: if (fall_w) begin
            if (cnt == 3'd7) begin
              sda_oe_o <= 1'b0; st <= BUS_HACK;
            end else begin
              cnt <= cnt + 3'd1; txb <= {txb[6:0], 1'b0}; sda_oe_o <= ~txb[6];
            end
          end
          BUS_HACK: begin
            if (rise_w) begin
              if (!sda_i) begin ptr_o <= ptr_o + 8'd1; got8 <= 1'b1; end
              else st <= BUS_IDLE;
            end else if (fall_w && got8) begin
              got8 <= 1'b0; cnt <= '0; st <= BUS_TX;
              txb <= rd_data_i; sda_oe_o <= ~rd_data_i[7];
            end
          end
          default: ;
        endcase
      end
    end
  end

  a_r8_stop_release: assert property (@(posedge clk) disable iff (!rst_n)
    stop_w && !pin_rise_w |=> !sda_oe_o && st == BUS_IDLE);
  a_r9_pin_abort: assert property (@(posedge clk) disable iff (!rst_n)
    pin_rise_w |=> !sda_oe_o && st == BUS_IDLE);
  a_r2_ptr_step: assert property (@(posedge clk) disable iff (!rst_n)
    wr_o |-> ptr_o == 8'(wr_addr_o + 8'd1));
  a_r3_tx_in_read: assert property (@(posedge clk) disable iff (!rst_n)
    (st == BUS_TX || st == BUS_HACK) |-> rd_mode);
  a_r1_quiet_idle: assert property (@(posedge clk) disable iff (!rst_n)
    st == BUS_IDLE |-> !sda_oe_o);
endmodule

// File: rtl/ledreg_file.sv
`timescale 1ns/1ps
module ledreg_file
  import ledreg_pkg::*;
#(
  parameter int unsigned CH   = CH_N,
  parameter int unsigned NREG = REG_N
)(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_i,
  input  logic [7:0]           waddr_i,
  input  logic [7:0]           wdata_i,
  input  logic                 pin_i,
  input  logic [7:0]           raddr_i,
  output logic [7:0]           rdata_o,
  output logic [7:0]           ctrl_o,
  output logic [CH*FINE_W-1:0] fine_o,
  output logic [CH*8-1:0]      coarse_o,
  output logic [7:0]           cur_g_o,
  output logic [7:0]           cur_r_o,
  output logic [7:0]           cur_b_o,
  output logic [7:0]           phase_o
);
  localparam int unsigned NDUTY = 3 * CH;
  localparam int unsigned AW    = $clog2(NREG);

  logic [7:0] stg [NREG];
  logic [7:0] act [NDUTY];

  wire upd_w = wr_i && waddr_i == UPD_A && wdata_i == 8'h00 && pin_i && stg[0][0];
  wire clr_w = wr_i && waddr_i == CLR_A && wdata_i == 8'h00;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) stg[i] <= '0;
      for (int i = 0; i < NDUTY; i++) act[i] <= '0;
    end else if (clr_w) begin
      for (int i = 0; i < NREG; i++) stg[i] <= '0;
      for (int i = 0; i < NDUTY; i++) act[i] <= '0;
    end else begin
      if (wr_i && waddr_i < 8'(NREG)) stg[waddr_i[AW-1:0]] <= wdata_i & reg_mask(waddr_i);
      if (upd_w) for (int i = 0; i < NDUTY; i++) act[i] <= stg[i+1];
    end
  end

  assign rdata_o  = (raddr_i < 8'(NREG)) ? stg[raddr_i[AW-1:0]] : 8'h00;
  assign ctrl_o   = stg[CTRL_A];
  assign cur_g_o  = stg[GCC_A];
  assign cur_r_o  = stg[GCC_A + 8'd1];
  assign cur_b_o  = stg[GCC_A + 8'd2];
  assign phase_o  = stg[PHS_A];

  for (genvar k = 0; k < CH; k++) begin : g_ch
    assign fine_o[k*FINE_W +: FINE_W] = {act[2*k+1][FINE_W-BYTE_W-1:0], act[2*k]};
    assign coarse_o[k*8 +: 8]         = act[2*CH+k];
  end

  a_r5_duty_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_w && !clr_w |=> $stable(fine_o) && $stable(coarse_o));
  a_r6_clear_all: assert property (@(posedge clk) disable iff (!rst_n)
    clr_w |=> ctrl_o == 8'h00 && fine_o == '0 && coarse_o == '0 &&
              cur_g_o == 8'h00 && cur_r_o == 8'h00 && cur_b_o == 8'h00 && phase_o == 8'h00);
  a_r4_ctrl_unused: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_o & ~CTRL_M) == 8'h00);
  a_r7_ctrl_follow: assert property (@(posedge clk) disable iff (!rst_n)
    wr_i && waddr_i == CTRL_A |=> ctrl_o == ($past(wdata_i) & CTRL_M));
endmodule

// File: rtl/ledreg_i2c_target.sv
`timescale 1ns/1ps
module ledreg_i2c_target
  import ledreg_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   scl_i,
  input  logic                   sda_i,
  output logic                   sda_oe_o,
  input  logic [1:0]             strap_i,
  input  logic                   pin_i,
  output logic [7:0]             ctrl_o,
  output logic [CH_N*FINE_W-1:0] fine_o,
  output logic [CH_N*8-1:0]      coarse_o,
  output logic [7:0]             cur_g_o,
  output logic [7:0]             cur_r_o,
  output logic [7:0]             cur_b_o,
  output logic [7:0]             phase_o
);
  logic       wr_w;
  logic [7:0] waddr_w, wdata_w, ptr_w, rdata_w;

  ledreg_bus i_bus (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i), .strap_i(strap_i),
    .pin_i(pin_i), .rd_data_i(rdata_w), .sda_oe_o(sda_oe_o), .wr_o(wr_w),
    .wr_addr_o(waddr_w), .wr_data_o(wdata_w), .ptr_o(ptr_w)
  );

  ledreg_file #(.CH(CH_N), .NREG(REG_N)) i_file (
    .clk(clk), .rst_n(rst_n), .wr_i(wr_w), .waddr_i(waddr_w), .wdata_i(wdata_w),
    .pin_i(pin_i), .raddr_i(ptr_w), .rdata_o(rdata_w), .ctrl_o(ctrl_o),
    .fine_o(fine_o), .coarse_o(coarse_o), .cur_g_o(cur_g_o), .cur_r_o(cur_r_o),
    .cur_b_o(cur_b_o), .phase_o(phase_o)
  );
endmodule

// File: tb/test_ledreg_i2c_target.sv
`timescale 1ns/1ps
module test_ledreg_i2c_target;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_h = 1'b1, sda_h = 1'b1, pin = 1'b1;
  logic [1:0] strap = 2'b10;
  logic sda_oe;
  logic [7:0] ctrl, cur_g, cur_r, cur_b, phase;
  logic [359:0] fine;
  logic [287:0] coarse;
  wire line = sda_h & ~sda_oe;
  int checks = 0, errs = 0;
  bit done = 0;

  localparam logic [7:0] DW = 8'h64;
  localparam logic [7:0] DR = 8'h65;

  always #2.5 clk = ~clk;

  ledreg_i2c_target i_ledreg_i2c_target (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_h), .sda_i(line), .sda_oe_o(sda_oe),
    .strap_i(strap), .pin_i(pin), .ctrl_o(ctrl), .fine_o(fine), .coarse_o(coarse),
    .cur_g_o(cur_g), .cur_r_o(cur_r), .cur_b_o(cur_b), .phase_o(phase)
  );

  // {register, value written, value expected on read back}
  localparam int NV = 13;
  localparam logic [23:0] VEC [NV] = '{
    24'h00_FF_73, 24'h01_A5_A5, 24'h02_FF_03, 24'h49_3C_3C, 24'h6C_81_81,
    24'h6E_11_11, 24'h6F_22_22, 24'h70_33_33, 24'h71_C7_C7, 24'h6D_55_00,
    24'h7F_5A_00, 24'h72_AB_00, 24'h01_00_A5 };

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errs++;
      $display("FAIL %s got %h exp %h", tag, got, exp);
    end
  endtask

  task automatic hp();
    repeat (4) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_h = 1'b1; hp(); scl_h = 1'b1; hp(); sda_h = 1'b0; hp(); scl_h = 1'b0; hp();
  endtask

  task automatic bus_stop();
    sda_h = 1'b0; hp(); scl_h = 1'b1; hp(); sda_h = 1'b1; hp();
  endtask

  task automatic send_byte(input logic [7:0] b, output logic nack);
    for (int i = 7; i >= 0; i--) begin
      sda_h = b[i]; hp(); scl_h = 1'b1; hp(); scl_h = 1'b0; hp();
    end
    sda_h = 1'b1; hp(); scl_h = 1'b1; hp(); nack = line; scl_h = 1'b0; hp();
  endtask

  task automatic recv_byte(input logic ack, output logic [7:0] b);
    sda_h = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      hp(); scl_h = 1'b1; hp(); b[i] = line; scl_h = 1'b0;
    end
    hp(); sda_h = ~ack; hp(); scl_h = 1'b1; hp(); scl_h = 1'b0; hp(); sda_h = 1'b1;
  endtask

  task automatic wr_reg(input logic [7:0] a, input logic [7:0] d, output logic nk);
    logic n0, n1, n2;
    bus_start(); send_byte(DW, n0); send_byte(a, n1); send_byte(d, n2); bus_stop();
    nk = n0 | n1 | n2;
  endtask

  task automatic rd_reg(input logic [7:0] a, output logic [7:0] d);
    logic n;
    bus_start(); send_byte(DW, n); send_byte(a, n);
    bus_start(); send_byte(DR, n); recv_byte(1'b0, d); bus_stop();
  endtask

  initial begin
    logic nk;
    logic [7:0] d;
    repeat (5) @(negedge clk);
    // R10: reset state
    chk("R10 ctrl", 32'(ctrl), 0);
    chk("R10 fine", 32'(|fine), 0);
    chk("R10 coarse", 32'(|coarse), 0);
    chk("R10 sda_oe", 32'(sda_oe), 0);
    rst_n = 1'b1;
    hp();

    // R4 register map, R6 nonzero clear ignored, R1 acknowledge
    for (int v = 0; v < NV; v++) begin
      if (VEC[v][15:8] != 8'h00 || VEC[v][23:16] != 8'h01) begin
        wr_reg(VEC[v][23:16], VEC[v][15:8], nk);
        chk("R1 ack on write", 32'(nk), 0);
      end
      rd_reg(VEC[v][23:16], d);
      chk("R4 readback", 32'(d), 32'(VEC[v][7:0]));
    end

    // R7: immediate registers
    chk("R7 ctrl", 32'(ctrl), 32'h73);
    chk("R7 cur_g", 32'(cur_g), 32'h11);
    chk("R7 cur_r", 32'(cur_r), 32'h22);
    chk("R7 cur_b", 32'(cur_b), 32'h33);
    chk("R7 phase", 32'(phase), 32'hC7);
    chk("R5 staged not active", 32'(|fine), 0);

    // R2: multi-byte write with auto-increment
    begin
      logic n0, n1, n2, n3, n4, n5;
      bus_start(); send_byte(DW, n0); send_byte(8'h01, n1);
      send_byte(8'h10, n2); send_byte(8'h01, n3); send_byte(8'h20, n4); send_byte(8'h02, n5);
      bus_stop();
      chk("R2 burst ack", 32'({n0, n1, n2, n3, n4, n5}), 0);
    end
    // R3: sequential read
    begin
      logic n;
      logic [7:0] b0, b1, b2, b3;
      bus_start(); send_byte(DW, n); send_byte(8'h01, n);
      bus_start(); send_byte(DR, n);
      recv_byte(1'b1, b0); recv_byte(1'b1, b1); recv_byte(1'b1, b2); recv_byte(1'b0, b3);
      bus_stop();
      chk("R3 seq read", {b0, b1, b2, b3}, 32'h10012002);
      chk("R3 released after nack", 32'(sda_oe), 0);
    end

    // R5: update gating
    wr_reg(8'h00, 8'h72, nk);
    wr_reg(8'h6D, 8'h00, nk);
    chk("R5 no update when ctrl bit0=0", 32'(|fine), 0);
    wr_reg(8'h00, 8'h73, nk);
    pin = 1'b0; hp();
    wr_reg(8'h6D, 8'h00, nk);
    chk("R5 no update with pin low", 32'(|fine), 0);
    pin = 1'b1; hp();
    wr_reg(8'h6D, 8'h00, nk);
    chk("R11 fine ch0", 32'(fine[9:0]), 32'h110);
    chk("R11 fine ch1", 32'(fine[19:10]), 32'h220);
    chk("R11 coarse ch0", 32'(coarse[7:0]), 32'h3C);
    chk("R11 coarse ch35", 32'(coarse[287:280]), 32'h81);
    wr_reg(8'h01, 8'h55, nk);
    chk("R5 later write staged", 32'(fine[9:0]), 32'h110);

    // R1: wrong address is ignored
    begin
      logic n0, n1;
      bus_start(); send_byte(8'h66, n0); send_byte(8'h6E, n1); bus_stop();
      chk("R1 nack address", 32'(n0), 1);
      chk("R1 nack following byte", 32'(n1), 1);
    end

    // R8: STOP in the middle of a byte
    begin
      logic n;
      bus_start(); send_byte(DW, n);
      for (int i = 0; i < 4; i++) begin
        sda_h = 1'b1; hp(); scl_h = 1'b1; hp(); scl_h = 1'b0; hp();
      end
      bus_stop();
      chk("R8 released after stop", 32'(sda_oe), 0);
      rd_reg(8'h6E, d);
      chk("R8 next transfer", 32'(d), 32'h11);
    end

    // R9: shutdown pin edge aborts
    begin
      logic n0, n1, n2;
      bus_start(); send_byte(DW, n0); send_byte(8'h6F, n1);
      pin = 1'b0; hp(); pin = 1'b1; hp();
      send_byte(8'h99, n2); bus_stop();
      chk("R9 byte after pin edge nacked", 32'(n2), 1);
      chk("R9 register kept", 32'(cur_r), 32'h22);
    end

    // R6: clear
    wr_reg(8'h7F, 8'h00, nk);
    chk("R6 ctrl cleared", 32'(ctrl), 0);
    chk("R6 cur_g cleared", 32'(cur_g), 0);
    chk("R6 fine cleared", 32'(|fine), 0);
    chk("R6 coarse cleared", 32'(|coarse), 0);
    rd_reg(8'h49, d);
    chk("R6 staged cleared", 32'(d), 0);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errs);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errs++;
      $display("FAIL watchdog got timeout exp completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errs);
      $finish;
    end
  end
endmodule